// File: doc/BRIEF.md
# Tile Mesh Link Switch

This block is the routing switch that sits beside each processor core in a two-dimensional mesh of tiles. The tile has eight incoming and eight outgoing links. Each link carries a 16-bit word, a valid strobe and a request line that runs back from the receiver; the link clock is treated as the local clock here, since crossing between clock domains lies outside this block. The core sends one word to any set of the outgoing links in a single write. It receives from two incoming links, picked by static settings, through two 64-entry input FIFOs.

Outgoing links that the core does not own can instead be tied to an incoming link as pass-through routes. These carry long-distance traffic across the tile without the core taking part. Each route is either combinational or has one register stage. A route's backpressure passes straight back to its source link. The settings are static and may change only while the links they affect are idle.

Top module: `mesh_tile_switch`

## Requirements
- R1: While reset is held, and on the first cycle after it, every lnk_out_valid bit is 0, both core_rd_empty bits are 1 and core_wr_stall is 0.
- R2: A core write that is accepted (core_wr_en high, with no stall and no error) makes lnk_out_valid[o] equal core_wr_mask[o] on the next cycle for every output o with cfg_pass_en[o]=0. Every lane that is marked carries core_wr_data. Each output that is not a route shows valid 0 on any cycle that does not follow an accepted write.
- R3: core_wr_stall is high in the same cycle whenever core_wr_en is high, there is no error, and any output with its core_wr_mask bit set has lnk_out_req low. A stalled write sends nothing.
- R4: cfg_fifo_src holds two 3-bit port numbers: bits [2:0] feed FIFO 0 and bits [5:3] feed FIFO 1. When lnk_in_valid is high on the chosen port, its word is pushed into that FIFO. Words come out in the order they went in.
- R5: Each input FIFO holds 64 words. A push that arrives while the FIFO is full is dropped.
- R6: The request line of a port that feeds a FIFO is high exactly when that FIFO has more than 4 free entries, that is, when it holds 59 or fewer words.
- R7: An output with cfg_pass_en=1 and cfg_pass_reg=0 shows the valid and data of its source port in the same cycle. The source port number is given by cfg_pass_src bits [3*o+2:3*o].
- R8: An output with cfg_pass_en=1 and cfg_pass_reg=1 shows the valid and data its source port had one cycle earlier.
- R9: A port that is the source of a route has its request high only when lnk_out_req is high on every output that route drives.
- R10: core_wr_err is high in the same cycle when core_wr_en is high and core_wr_mask marks an output with cfg_pass_en=1. The whole write is dropped, and no output shows it.
- R11: A port that feeds neither FIFO nor any route keeps its lnk_in_req low.
- R12: core_rd_data shows the oldest word of each FIFO; bits [15:0] belong to FIFO 0. Raising core_rd_en[k] while FIFO k holds data removes that word at the clock edge. core_rd_empty[k] is high when FIFO k is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tile clock |
| rst_n | input | 1 | Active-low reset |
| lnk_in_data | input | 128 | Incoming words, port p in bits [16p+15:16p] |
| lnk_in_valid | input | 8 | Incoming valid strobes |
| lnk_in_req | output | 8 | Request back to each upstream sender |
| lnk_out_data | output | 128 | Outgoing words, port o in bits [16o+15:16o] |
| lnk_out_valid | output | 8 | Outgoing valid strobes |
| lnk_out_req | input | 8 | Request from each downstream receiver |
| core_wr_en | input | 1 | Core write strobe |
| core_wr_mask | input | 8 | Outputs targeted by the write |
| core_wr_data | input | 16 | Word to send |
| core_wr_stall | output | 1 | Write held back by a receiver |
| core_wr_err | output | 1 | Write targets a routed output |
| core_rd_en | input | 2 | Pop strobes for FIFO 0 and FIFO 1 |
| core_rd_data | output | 32 | Oldest word of each FIFO |
| core_rd_empty | output | 2 | FIFO empty flags |
| cfg_fifo_src | input | 6 | Source port for each FIFO |
| cfg_pass_en | input | 8 | Output is a pass-through route |
| cfg_pass_reg | input | 8 | Route has a register stage |
| cfg_pass_src | input | 24 | Source port of each route, 3 bits per output |

## Verification
Some results respond in the same cycle: core_wr_stall, core_wr_err, unregistered routes, request lines, and the FIFO head on core_rd_data. The bench reads these shortly after it drives the inputs, at the falling edge. Core writes and registered routes show up one clock later, so the bench reads them at the next falling edge and compares them with the stimulus it stored on the cycle before. A FIFO push changes the count, and so the request line, at the rising edge that follows. The bench therefore works out the expected request level from the number of words already accepted, not counting the word being driven.

// File: rtl/mesh_tile_switch.sv
module mesh_tile_switch #(
  parameter int W        = 16,
  parameter int NP       = 8,
  parameter int DEPTH    = 64,
  parameter int HEADROOM = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NP*W-1:0]   lnk_in_data,
  input  logic [NP-1:0]     lnk_in_valid,
  output logic [NP-1:0]     lnk_in_req,
  output logic [NP*W-1:0]   lnk_out_data,
  output logic [NP-1:0]     lnk_out_valid,
  input  logic [NP-1:0]     lnk_out_req,
  input  logic              core_wr_en,
  input  logic [NP-1:0]     core_wr_mask,
  input  logic [W-1:0]      core_wr_data,
  output logic              core_wr_stall,
  output logic              core_wr_err,
  input  logic [1:0]        core_rd_en,
  output logic [2*W-1:0]    core_rd_data,
  output logic [1:0]        core_rd_empty,
  input  logic [2*$clog2(NP)-1:0]  cfg_fifo_src,
  input  logic [NP-1:0]     cfg_pass_en,
  input  logic [NP-1:0]     cfg_pass_reg,
  input  logic [NP*$clog2(NP)-1:0] cfg_pass_src
);
  localparam int SW = $clog2(NP);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          wr_fire;
  logic [NP-1:0] tx_valid_q;
  logic [W-1:0]  tx_data_q;
  logic [1:0]    fifo_room;
  logic [NP-1:0] port_used, port_ok;

  assign core_wr_err   = core_wr_en & |(core_wr_mask & cfg_pass_en);
  assign core_wr_stall = core_wr_en & ~core_wr_err & |(core_wr_mask & ~lnk_out_req);
  assign wr_fire       = core_wr_en & ~core_wr_err & ~core_wr_stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_valid_q <= '0;
    else        tx_valid_q <= wr_fire ? core_wr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (wr_fire) tx_data_q <= core_wr_data;
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    logic [SW-1:0] src;
    logic          pv_q;
    logic [W-1:0]  pd_q;
    assign src = cfg_pass_src[o*SW +: SW];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pv_q <= 1'b0;
      else        pv_q <= lnk_in_valid[src];
    end
    always_ff @(posedge clk) pd_q <= lnk_in_data[src*W +: W];

    assign lnk_out_valid[o] = !cfg_pass_en[o] ? tx_valid_q[o] :
                              cfg_pass_reg[o] ? pv_q : lnk_in_valid[src];
    assign lnk_out_data[o*W +: W] = !cfg_pass_en[o] ? tx_data_q :
                                    cfg_pass_reg[o] ? pd_q : lnk_in_data[src*W +: W];
  end

  for (genvar k = 0; k < 2; k++) begin : g_fifo
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic [SW-1:0] sel;
    logic          push, pop;

    assign sel  = cfg_fifo_src[k*SW +: SW];
    assign push = lnk_in_valid[sel] & (cnt != CW'(DEPTH));
    assign pop  = core_rd_en[k] & (cnt != '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
      end
    end

    always_ff @(posedge clk) begin
      if (push) mem[wp] <= lnk_in_data[sel*W +: W];
    end

    assign core_rd_data[k*W +: W] = mem[rp];
    assign core_rd_empty[k]       = (cnt == '0);
    assign fifo_room[k]           = cnt < CW'(DEPTH - HEADROOM);
  end

  always_comb begin
    port_used = '0;
    port_ok   = '1;
    for (int p = 0; p < NP; p++) begin
      for (int k = 0; k < 2; k++) begin
        if (cfg_fifo_src[k*SW +: SW] == SW'(p)) begin
          port_used[p] = 1'b1;
          port_ok[p]   = port_ok[p] & fifo_room[k];
        end
      end
      for (int o = 0; o < NP; o++) begin
        if (cfg_pass_en[o] && cfg_pass_src[o*SW +: SW] == SW'(p)) begin
          port_used[p] = 1'b1;
          port_ok[p]   = port_ok[p] & lnk_out_req[o];
        end
      end
    end
  end

  assign lnk_in_req = port_used & port_ok;
endmodule

// File: rtl/mesh_tile_switch_chk.sv
module mesh_tile_switch_chk #(
  parameter int W  = 16,
  parameter int NP = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NP-1:0]           lnk_in_valid,
  input logic [NP-1:0]           lnk_in_req,
  input logic [NP-1:0]           lnk_out_valid,
  input logic [NP-1:0]           lnk_out_req,
  input logic                    core_wr_en,
  input logic [NP-1:0]           core_wr_mask,
  input logic                    core_wr_stall,
  input logic                    core_wr_err,
  input logic [NP-1:0]           cfg_pass_en,
  input logic [NP-1:0]           cfg_pass_reg,
  input logic [NP*$clog2(NP)-1:0] cfg_pass_src
);
  localparam int SW = $clog2(NP);
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  a_r3_stall_sends_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_stall |=> ((lnk_out_valid & ~cfg_pass_en) == '0));

  a_r10_err_sends_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_err |=> ((lnk_out_valid & ~cfg_pass_en) == '0));

  a_r2_mask_delivered: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr_en && !core_wr_stall && !core_wr_err) |=>
      ((lnk_out_valid & ~cfg_pass_en) == ($past(core_wr_mask) & ~cfg_pass_en)));

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !core_wr_en |=> ((lnk_out_valid & ~cfg_pass_en) == '0));

  for (genvar o = 0; o < NP; o++) begin : g_route
    a_r8_reg_route_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && cfg_pass_en[o] && cfg_pass_reg[o] && $past(cfg_pass_en[o] && cfg_pass_reg[o])
        && $stable(cfg_pass_src[o*SW +: SW]))
        |-> (lnk_out_valid[o] == $past(lnk_in_valid[cfg_pass_src[o*SW +: SW]])));

    a_r9_route_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pass_en[o] && !lnk_out_req[o]) |-> !lnk_in_req[cfg_pass_src[o*SW +: SW]]);
  end
endmodule

bind mesh_tile_switch mesh_tile_switch_chk #(.W(W), .NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lnk_in_valid(lnk_in_valid), .lnk_in_req(lnk_in_req),
  .lnk_out_valid(lnk_out_valid), .lnk_out_req(lnk_out_req),
  .core_wr_en(core_wr_en), .core_wr_mask(core_wr_mask),
  .core_wr_stall(core_wr_stall), .core_wr_err(core_wr_err),
  .cfg_pass_en(cfg_pass_en), .cfg_pass_reg(cfg_pass_reg), .cfg_pass_src(cfg_pass_src)
);

// File: tb/mesh_tile_switch_tb.sv
`timescale 1ns/1ps
module mesh_tile_switch_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] lnk_in_data = '0;
  logic [7:0]   lnk_in_valid = '0;
  logic [7:0]   lnk_in_req;
  logic [127:0] lnk_out_data;
  logic [7:0]   lnk_out_valid;
  logic [7:0]   lnk_out_req = 8'hFF;
  logic         core_wr_en = 1'b0;
  logic [7:0]   core_wr_mask = '0;
  logic [15:0]  core_wr_data = '0;
  logic         core_wr_stall, core_wr_err;
  logic [1:0]   core_rd_en = '0;
  logic [31:0]  core_rd_data;
  logic [1:0]   core_rd_empty;
  logic [5:0]   cfg_fifo_src = {3'd5, 3'd3};
  logic [7:0]   cfg_pass_en = '0;
  logic [7:0]   cfg_pass_reg = '0;
  logic [23:0]  cfg_pass_src = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mesh_tile_switch u_dut (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word(input int j, input int seed);
    return 16'((j * 97 + seed * 1031 + 5) & 16'hFFFF);
  endfunction

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(lnk_out_valid == 8'h00 && core_rd_empty == 2'b11 && !core_wr_stall, "R1 in reset",
        {lnk_out_valid, core_rd_empty}, 32'h003);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(lnk_out_valid == 8'h00 && core_rd_empty == 2'b11 && !core_wr_stall, "R1 after reset",
        {lnk_out_valid, core_rd_empty}, 32'h003);
    chk(lnk_in_req == 8'b0010_1000, "R11 R6 idle request", lnk_in_req, 8'b0010_1000);

    // R2: every mask with all receivers ready
    for (int m = 0; m < 256; m++) begin
      logic [15:0] d;
      bit ok;
      d = 16'(m * 257) ^ 16'h5A5A;
      @(negedge clk);
      core_wr_en = 1'b1; core_wr_mask = 8'(m); core_wr_data = d;
      #1 chk(!core_wr_stall && !core_wr_err, "R2 no stall", {core_wr_stall, core_wr_err}, 0);
      @(negedge clk);
      core_wr_en = 1'b0;
      #1;
      ok = (lnk_out_valid == 8'(m));
      for (int o = 0; o < 8; o++)
        if (m[o] && lnk_out_data[o*16 +: 16] != d) ok = 1'b0;
      chk(ok, "R2 mask delivered", lnk_out_valid, m);
    end
    @(negedge clk) #1;
    chk(lnk_out_valid == 8'h00, "R2 idle quiet", lnk_out_valid, 0);

    // R3: one receiver not ready, every mask
    for (int i = 0; i < 8; i++) begin
      for (int m = 0; m < 256; m++) begin
        bit blk;
        blk = m[i];
        @(negedge clk);
        lnk_out_req = ~(8'd1 << i);
        core_wr_en = 1'b1; core_wr_mask = 8'(m); core_wr_data = 16'(i * 256 + m);
        #1 chk(core_wr_stall == blk, "R3 stall flag", core_wr_stall, blk);
        @(negedge clk);
        core_wr_en = 1'b0;
        #1 chk(lnk_out_valid == (blk ? 8'h00 : 8'(m)), "R3 stalled write withheld",
               lnk_out_valid, blk ? 0 : m);
      end
    end
    @(negedge clk) lnk_out_req = 8'hFF;

    // R4 R5 R6: fill FIFO 0 from port 3, one extra push when full
    for (int j = 0; j < 65; j++) begin
      @(negedge clk);
      lnk_in_valid[3] = 1'b1;
      lnk_in_data[3*16 +: 16] = word(j, 0);
      #1 chk(lnk_in_req[3] == (j < 60), "R6 request threshold", lnk_in_req[3], j < 60);
    end
    @(negedge clk) lnk_in_valid[3] = 1'b0;
    #1 chk(core_rd_empty == 2'b10, "R4 R12 FIFO 0 holds data", core_rd_empty, 2'b10);

    // R12 R5: drain, order kept, extra word absent
    for (int j = 0; j < 64; j++) begin
      @(negedge clk);
      core_rd_en = 2'b01;
      #1 chk(core_rd_data[15:0] == word(j, 0), "R4 R12 order", core_rd_data[15:0], word(j, 0));
    end
    @(negedge clk) core_rd_en = 2'b00;
    #1 chk(core_rd_empty[0] && lnk_in_req[3], "R5 full push dropped",
           {core_rd_empty[0], lnk_in_req[3]}, 2'b11);

    // R4: both FIFOs at once, port 4 feeds neither
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      lnk_in_valid = 8'b0011_1000;
      lnk_in_data[3*16 +: 16] = word(j, 1);
      lnk_in_data[4*16 +: 16] = 16'hDEAD;
      lnk_in_data[5*16 +: 16] = word(j, 2);
    end
    @(negedge clk) lnk_in_valid = '0;
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      core_rd_en = 2'b11;
      #1 chk(core_rd_data == {word(j, 2), word(j, 1)}, "R4 two FIFOs",
             core_rd_data, {word(j, 2), word(j, 1)});
    end
    @(negedge clk) core_rd_en = 2'b00;
    #1 chk(core_rd_empty == 2'b11, "R4 R11 unselected port ignored", core_rd_empty, 2'b11);

    // routes: out6 <- port2 unregistered, out7 <- port4 registered
    @(negedge clk);
    cfg_pass_src[6*3 +: 3] = 3'd2;
    cfg_pass_src[7*3 +: 3] = 3'd4;
    cfg_pass_reg = 8'b1000_0000;
    cfg_pass_en  = 8'b1100_0000;
    repeat (2) @(negedge clk);
    #1 chk(lnk_in_req == 8'b0011_1100, "R11 R9 request with routes", lnk_in_req, 8'b0011_1100);
    begin
      logic        pv;
      logic [15:0] pd;
      pv = 1'b0; pd = '0;
      for (int v = 0; v < 32; v++) begin
        logic [15:0] d2, d4;
        d2 = 16'(v * 37 + 11);
        d4 = 16'(v * 91 + 3);
        @(negedge clk);
        lnk_in_valid[2] = v[0]; lnk_in_data[2*16 +: 16] = d2;
        lnk_in_valid[4] = v[1]; lnk_in_data[4*16 +: 16] = d4;
        #1;
        chk(lnk_out_valid[6] == v[0] && lnk_out_data[6*16 +: 16] == d2, "R7 direct route",
            lnk_out_data[6*16 +: 16], d2);
        chk(lnk_out_valid[7] == pv && (!pv || lnk_out_data[7*16 +: 16] == pd), "R8 registered route",
            {lnk_out_valid[7], lnk_out_data[7*16 +: 16]}, {pv, pd});
        pv = v[1]; pd = d4;
      end
    end
    @(negedge clk) lnk_in_valid = '0;

    // R9: route backpressure
    lnk_out_req = 8'b0111_1111;
    #1 chk(!lnk_in_req[4] && lnk_in_req[2], "R9 registered route req", lnk_in_req, 8'b0010_1100);
    @(negedge clk) lnk_out_req = 8'b1011_1111;
    #1 chk(!lnk_in_req[2] && lnk_in_req[4], "R9 direct route req", lnk_in_req, 8'b0011_1000);
    @(negedge clk) lnk_out_req = 8'hFF;

    // R10: write touching a routed output is dropped
    @(negedge clk);
    core_wr_en = 1'b1; core_wr_mask = 8'b0100_0001; core_wr_data = 16'h1234;
    #1 chk(core_wr_err && !core_wr_stall, "R10 error flag", {core_wr_err, core_wr_stall}, 2'b10);
    @(negedge clk) core_wr_en = 1'b0;
    #1 chk((lnk_out_valid & 8'h3F) == 8'h00, "R10 write dropped", lnk_out_valid, 0);

    // R2: core lanes still work beside routes
    @(negedge clk);
    core_wr_en = 1'b1; core_wr_mask = 8'h3F; core_wr_data = 16'hBEEF;
    @(negedge clk) core_wr_en = 1'b0;
    #1 chk((lnk_out_valid & 8'h3F) == 8'h3F && lnk_out_data[0 +: 16] == 16'hBEEF,
           "R2 write beside routes", lnk_out_valid, 8'h3F);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule